// File: doc/BRIEF.md
# Per-Channel Pseudo-Random Sequence Monitor

This block watches the sample words arriving on each converter channel and decides whether they form one of two pseudo-random bit sequences. Every sample word carries DATA_W consecutive bits of the sequence, oldest bit in the MSB. The checker predicts each incoming bit from the bits it has already received. It therefore needs no seed and picks up the sequence again on its own after any disturbance.

A small register window lets software pick the sequence for each channel and read two sticky status flags. One flag records a sustained loss of lock. The other records isolated mismatches while the link is locked. Software writes ones to clear both flags, waits while traffic flows, and reads them back. If both are still clear, the link carried the sequence without error.

Top module: `prbs_mon`

## Requirements
- R1: After reset every channel has both status flags clear and its pattern-select field at 0.
- R2: The pattern select is a 4-bit field at bits 19:16 of the word at 0x418 + 0x40*ch, and it reads back as written. Value 0 selects the recurrence b[n] = b[n-9] ^ b[n-5], and value 1 selects b[n] = b[n-23] ^ b[n-18]. Bits enter the stream MSB first within each sample word.
- R3: The status word at 0x404 + 0x40*ch shows the out-of-sync flag at bit 1 and the spurious flag at bit 2. All its other bits read 0. Any address outside a channel's control or status word reads 0.
- R4: Writing a 1 to a status bit clears that flag. Writing a 0 leaves it unchanged.
- R5: An unlocked channel becomes locked after 16 consecutive matching samples. Every checked sample taken while the channel stays unlocked sets the out-of-sync flag.
- R6: A mismatching sample on a locked channel sets the spurious flag. Four consecutive mismatching samples drop the lock and set the out-of-sync flag.
- R7: Whenever the out-of-sync flag is set, the spurious flag is held clear.
- R8: A select value other than 0 or 1 disables checking on that channel. Its samples are then ignored, and its flags, lock state and bit history all hold.
- R9: If a flag is set by a sample in the same cycle that software writes a 1 to clear it, the set wins.
- R10: A window of zeros as long as the selected sequence (9 or 23 bits) counts as a mismatch, so a stuck-low lane never looks locked.
- R11: Channels are checked and reported independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | NUM_CH | Per-channel sample strobe |
| smp_data_i | input | NUM_CH*DATA_W | Per-channel sample words, channel 0 in the low bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address for writes and reads |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for reg_addr_i, combinational |

## Verification
Two events can land on the same flag in the same clock: a software clear, and a sample that sets that flag. The bench provokes this by presenting a corrupted word on a locked channel in the same cycle as a write of ones to its status word. It then expects to read the spurious flag set. A second collision happens inside the flag logic. The fourth consecutive mismatch sets out-of-sync and forces the spurious flag clear in one update, and the bench checks this by reading the status after the third and after the fourth inverted word.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  localparam int SEL_W     = 4;
  localparam int SEL_LSB   = 16;
  localparam int BIT_OOS   = 1;
  localparam int BIT_ERR   = 2;
  localparam int SLOT_LOG2 = 6;
  localparam logic [SLOT_LOG2-1:0] OFS_STAT = 6'h04;
  localparam logic [SLOT_LOG2-1:0] OFS_CTL3 = 6'h18;

  localparam int LEN9   = 9;
  localparam int TAP9   = 5;
  localparam int LEN23  = 23;
  localparam int TAP23  = 18;
  localparam int HIST_W = LEN23;

  typedef enum logic [1:0] {
    PAT_P9  = 2'd0,
    PAT_P23 = 2'd1,
    PAT_OFF = 2'd2
  } pat_e;

  function automatic pat_e pat_decode(input logic [SEL_W-1:0] s);
    case (s)
      4'd0:    return PAT_P9;
      4'd1:    return PAT_P23;
      default: return PAT_OFF;
    endcase
  endfunction
endpackage

// File: rtl/prbs_mon_lane.sv
module prbs_mon_lane
  import prbs_mon_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  pat_e              pat_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              chk_o,
  output logic              miss_o
);
  localparam int EXT_W = HIST_W + DATA_W;

  logic [HIST_W-1:0] hist_q;
  logic [EXT_W-1:0]  ext;
  logic              bit_err;
  logic              stuck;

  // ext[m] is newer than ext[m+1]; taps look back into older bits
  assign ext   = {hist_q, data_i};
  assign chk_o = valid_i && (pat_i != PAT_OFF);

  always_comb begin
    bit_err = 1'b0;
    for (int m = 0; m < DATA_W; m++) begin
      if (pat_i == PAT_P23) bit_err |= ext[m] ^ ext[m+LEN23] ^ ext[m+TAP23];
      else                  bit_err |= ext[m] ^ ext[m+LEN9]  ^ ext[m+TAP9];
    end
  end

  // all-zero window satisfies the recurrence but never occurs in a real sequence
  assign stuck  = (pat_i == PAT_P23) ? (ext[LEN23-1:0] == '0) : (ext[LEN9-1:0] == '0);
  assign miss_o = bit_err | stuck;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (chk_o) hist_q <= ext[HIST_W-1:0];
  end

  assert_hist_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || pat_i == PAT_OFF) |=> $stable(hist_q));

  assert_stuck_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pat_i == PAT_P9 && data_i[LEN9-1:0] == '0) |-> miss_o);
endmodule

// File: rtl/prbs_mon_lock.sv
module prbs_mon_lock #(
  parameter int LOCK_HITS = 16,
  parameter int LOSS_MISS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chk_i,
  input  logic miss_i,
  input  logic clr_oos_i,
  input  logic clr_err_i,
  output logic oos_o,
  output logic err_o
);
  localparam int HIT_W  = $clog2(LOCK_HITS);
  localparam int MISS_W = $clog2(LOSS_MISS);
  localparam logic [HIT_W-1:0]  HIT_LAST  = HIT_W'(LOCK_HITS - 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_MISS - 1);

  logic              locked_q, locked_n;
  logic [HIT_W-1:0]  hit_q, hit_n;
  logic [MISS_W-1:0] miss_q, miss_n;
  logic              oos_q, oos_n, err_q, err_n;
  logic              set_oos, set_err;

  always_comb begin
    locked_n = locked_q;
    hit_n    = hit_q;
    miss_n   = miss_q;
    if (chk_i) begin
      if (locked_q) begin
        if (!miss_i) miss_n = '0;
        else if (miss_q == MISS_LAST) begin
          locked_n = 1'b0;
          miss_n   = '0;
          hit_n    = '0;
        end else miss_n = miss_q + 1'b1;
      end else begin
        if (miss_i) hit_n = '0;
        else if (hit_q == HIT_LAST) begin
          locked_n = 1'b1;
          hit_n    = '0;
          miss_n   = '0;
        end else hit_n = hit_q + 1'b1;
      end
    end
  end

  assign set_oos = chk_i && !locked_n;
  assign set_err = chk_i && miss_i && locked_n;
  assign oos_n   = set_oos | (oos_q & ~clr_oos_i);
  assign err_n   = !oos_n && (set_err | (err_q & ~clr_err_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      hit_q    <= '0;
      miss_q   <= '0;
      oos_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      locked_q <= locked_n;
      hit_q    <= hit_n;
      miss_q   <= miss_n;
      oos_q    <= oos_n;
      err_q    <= err_n;
    end
  end

  assign oos_o = oos_q;
  assign err_o = err_q;

  assert_lock_gain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(hit_q) == HIT_LAST && !$past(miss_i));

  assert_lock_loss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && miss_i && locked_q && miss_q == MISS_LAST) |=> (!locked_q && oos_q));

  assert_flag_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oos_q |-> !err_q);

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_i && miss_i && !locked_q) |=> oos_q);
endmodule

// File: rtl/prbs_mon_regs.sv
module prbs_mon_regs
  import prbs_mon_pkg::*;
#(
  parameter int                NUM_CH  = 2,
  parameter int                ADDR_W  = 16,
  parameter int                REG_W   = 32,
  parameter logic [ADDR_W-1:0] CH_BASE = 16'h0400
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [REG_W-1:0]                  wdata_i,
  input  logic [NUM_CH-1:0]                 oos_i,
  input  logic [NUM_CH-1:0]                 err_i,
  output logic [NUM_CH-1:0][SEL_W-1:0]      sel_o,
  output logic [NUM_CH-1:0]                 clr_oos_o,
  output logic [NUM_CH-1:0]                 clr_err_o,
  output logic [REG_W-1:0]                  rdata_o
);
  localparam int BLK_W = ADDR_W - SLOT_LOG2;
  localparam logic [BLK_W-1:0] BASE_BLK = CH_BASE[ADDR_W-1:SLOT_LOG2];

  logic [BLK_W-1:0]          blk;
  logic [SLOT_LOG2-1:0]      ofs;
  logic [NUM_CH-1:0]         hit;
  logic [NUM_CH-1:0][SEL_W-1:0] sel_q;

  assign blk = addr_i[ADDR_W-1:SLOT_LOG2];
  assign ofs = addr_i[SLOT_LOG2-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [BLK_W-1:0] MY_BLK = BASE_BLK + BLK_W'(c);
    logic st_wr, ctl_wr;

    assign hit[c]       = (blk == MY_BLK);
    assign st_wr        = wr_i && hit[c] && (ofs == OFS_STAT);
    assign ctl_wr       = wr_i && hit[c] && (ofs == OFS_CTL3);
    assign clr_oos_o[c] = st_wr && wdata_i[BIT_OOS];
    assign clr_err_o[c] = st_wr && wdata_i[BIT_ERR];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sel_q[c] <= '0;
      else if (ctl_wr) sel_q[c] <= wdata_i[SEL_LSB +: SEL_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c] && ofs == OFS_STAT) begin
        rdata_o[BIT_OOS] = oos_i[c];
        rdata_o[BIT_ERR] = err_i[c];
      end
      if (hit[c] && ofs == OFS_CTL3) rdata_o[SEL_LSB +: SEL_W] = sel_q[c];
    end
  end

  assign sel_o = sel_q;

  assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(sel_q));
endmodule

// File: rtl/prbs_mon.sv
module prbs_mon
  import prbs_mon_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int REG_W     = 32,
  parameter int LOCK_HITS = 16,
  parameter int LOSS_MISS = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH-1:0]        smp_valid_i,
  input  logic [NUM_CH*DATA_W-1:0] smp_data_i,
  input  logic                     reg_wr_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [REG_W-1:0]         reg_wdata_i,
  output logic [REG_W-1:0]         reg_rdata_o
);
  logic [NUM_CH-1:0][SEL_W-1:0] sel;
  logic [NUM_CH-1:0]            clr_oos, clr_err, oos, err, chk, miss;

  prbs_mon_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .oos_i     (oos),
    .err_i     (err),
    .sel_o     (sel),
    .clr_oos_o (clr_oos),
    .clr_err_o (clr_err),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pat_e pat;
    assign pat = pat_decode(sel[c]);

    prbs_mon_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (smp_valid_i[c]),
      .pat_i   (pat),
      .data_i  (smp_data_i[c*DATA_W +: DATA_W]),
      .chk_o   (chk[c]),
      .miss_o  (miss[c])
    );

    prbs_mon_lock #(
      .LOCK_HITS (LOCK_HITS),
      .LOSS_MISS (LOSS_MISS)
    ) u_lock (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .chk_i     (chk[c]),
      .miss_i    (miss[c]),
      .clr_oos_i (clr_oos[c]),
      .clr_err_i (clr_err[c]),
      .oos_o     (oos[c]),
      .err_o     (err[c])
    );
  end
endmodule

// File: tb/tb_prbs_mon.sv
module tb_prbs_mon;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] ST0 = 16'h0404, ST1 = 16'h0444;
  localparam logic [15:0] CT0 = 16'h0418, CT1 = 16'h0458;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  valid = '0;
  logic [31:0] data = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_vec = 0, n_err = 0;
  bit done = 1'b0;
  logic [22:0] gh [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_mon dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .smp_valid_i (valid),
    .smp_data_i  (data),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // bench-side sequence source: newest bit in gh[ch][0]
  task automatic gen(input int ch, input bit p23, output logic [15:0] w);
    logic nb;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      nb = p23 ? (gh[ch][22] ^ gh[ch][17]) : (gh[ch][8] ^ gh[ch][4]);
      gh[ch] = {gh[ch][21:0], nb};
      w = {w[14:0], nb};
    end
  endtask

  task automatic step(input logic [1:0] v, input logic [15:0] d0, input logic [15:0] d1,
                      input bit wr, input logic [15:0] a, input logic [31:0] wd);
    valid = v; data = {d1, d0}; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    valid = '0; reg_wr = 1'b0;
  endtask

  task automatic send0(input logic [15:0] w); step(2'b01, w, 16'h0, 1'b0, 16'h0, 32'h0); endtask
  task automatic send1(input logic [15:0] w); step(2'b10, 16'h0, w, 1'b0, 16'h0, 32'h0); endtask
  task automatic wreg(input logic [15:0] a, input logic [31:0] d); step(2'b00, 16'h0, 16'h0, 1'b1, a, d); endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic good0(input int n);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin gen(0, 1'b0, w); send0(w); end
  endtask

  task automatic good1(input int n);
    logic [15:0] w;
    for (int i = 0; i < n; i++) begin gen(1, 1'b1, w); send1(w); end
  endtask

  task automatic relock0();
    good0(24);
    wreg(ST0, 32'h6);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(ST0, d); check("R1 status ch0", d, 32'h0);
    rd(ST1, d); check("R1 status ch1", d, 32'h0);
    rd(CT0, d); check("R1 select ch0", d, 32'h0);
    rd(CT1, d); check("R1 select ch1", d, 32'h0);
  endtask

  task automatic t_lock9();
    logic [31:0] d;
    good0(24);
    rd(ST0, d); check("R5 out-of-sync seen before lock", d, 32'h2);
    wreg(ST0, 32'h6);
    good0(4);
    rd(ST0, d); check("R2 first sequence locked clean", d, 32'h0);
  endtask

  task automatic t_spurious();
    logic [31:0] d;
    logic [15:0] w;
    gen(0, 1'b0, w); send0(w ^ 16'h8000);
    rd(ST0, d); check("R6 single bit error sets spurious", d, 32'h4);
    good0(2);
    rd(ST0, d); check("R6 spurious is sticky, lock kept", d, 32'h4);
    wreg(ST0, 32'h4);
    rd(ST0, d); check("R4 write one clears spurious", d, 32'h0);
  endtask

  task automatic t_loss();
    logic [31:0] d;
    logic [15:0] w;
    for (int i = 0; i < 3; i++) begin gen(0, 1'b0, w); send0(~w); end
    rd(ST0, d); check("R6 three misses keep lock", d, 32'h4);
    gen(0, 1'b0, w); send0(~w);
    rd(ST0, d); check("R7 fourth miss sets oos, clears spurious", d, 32'h2);
    relock0();
    good0(2);
    rd(ST0, d); check("R5 relock after loss", d, 32'h0);
  endtask

  task automatic t_stuck();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) send0(16'h0000);
    rd(ST0, d); check("R10 stuck-low lane loses lock", d, 32'h2);
    relock0();
    good0(2);
    rd(ST0, d); check("R10 relock after stuck lane", d, 32'h0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    wreg(CT0, 32'h0005_0000);
    rd(CT0, d); check("R2 select readback", d, 32'h0005_0000);
    for (int i = 0; i < 6; i++) send0(16'hA5A5);
    rd(ST0, d); check("R8 samples ignored when disabled", d, 32'h0);
    wreg(CT0, 32'h0);
    good0(2);
    rd(ST0, d); check("R8 history and lock held", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    logic [15:0] w;
    gen(0, 1'b0, w);
    step(2'b01, w ^ 16'h8000, 16'h0, 1'b1, ST0, 32'h6);
    rd(ST0, d); check("R9 set beats same-cycle clear", d, 32'h4);
    wreg(ST0, 32'h0);
    rd(ST0, d); check("R4 writing zero keeps flag", d, 32'h4);
    wreg(ST0, 32'h4);
    rd(ST0, d); check("R4 write one clears", d, 32'h0);
  endtask

  task automatic t_chan23();
    logic [31:0] d;
    good1(24);
    wreg(ST1, 32'h6);
    good1(4);
    rd(ST1, d); check("R11 ch1 wrong sequence stays out of sync", d, 32'h2);
    rd(ST0, d); check("R11 ch0 unaffected by ch1", d, 32'h0);
    wreg(CT1, 32'h0001_0000);
    rd(CT1, d); check("R2 ch1 select readback", d, 32'h0001_0000);
    good1(24);
    wreg(ST1, 32'h6);
    good1(4);
    rd(ST1, d); check("R2 second sequence locked clean", d, 32'h0);
    rd(16'h0408, d); check("R3 unmapped offset reads zero", d, 32'h0);
    rd(16'h0484, d); check("R3 channel beyond range reads zero", d, 32'h0);
  endtask

  initial begin
    gh[0] = 23'h7FFFFF;
    gh[1] = 23'h5A5A5A;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock9();
    t_spurious();
    t_loss();
    t_stuck();
    t_disable();
    t_collide();
    t_chan23();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule